// File: doc/BRIEF.md
# VFD Controller Serial Command Receiver

This block is the receiving side of a character vacuum-fluorescent display controller. A host drives a three-wire serial link: a serial clock that idles high, a data line sampled on each rising serial-clock edge, and an active-low chip enable that frames each transfer. The block brings all three lines into the system clock domain through two-flop synchronizers. It assembles bytes least-significant bit first and treats the first byte of each frame as a command and every later byte as data.

Data bytes are held in a staging buffer while chip enable is low. When chip enable returns high, the frame is committed into one of the internal stores. These are the 16-digit character RAM, the additional-segment RAM, the user-defined-character pattern RAM, the brightness level, the grid count, the display mode and the 2-bit output port. Each RAM write starts at the address the command gives, and the address advances by one after every data byte. All stores can be read through combinational read ports.

Command encoding: the upper nibble of the command byte is the opcode and the lower nibble is its argument.

| Opcode | Function |
|---|---|
| 0x1 | Character RAM write |
| 0x2 | Pattern write |
| 0x3 | Additional-segment write |
| 0x4 | Port set |
| 0x5 | Brightness set |
| 0x6 | Grid count set |
| 0x7 | Display mode set |

Top module: `vfd_cmd_rx`

## Requirements
- R1: After reset, every character, segment and pattern entry reads 0, and brightness, grid count, port and display mode read 0 (display off).
- R2: Each byte is taken from the data line on 8 rising serial-clock edges, least-significant bit first, and the first complete byte of a frame is the command.
- R3: Command 0x1A (A = lower nibble) writes the following data bytes into character positions A, A+1, and so on, wrapping from 15 to 0. A later byte in the same frame overwrites an earlier one at the same position.
- R4: Command 0x3A writes bits [1:0] of each following data byte into segment entries A, A+1, and so on, wrapping from 15 to 0.
- R5: Command 0x2P writes bits [6:0] of the following data bytes into columns 0 to 4 of pattern P (P = bits [2:0]). The column wraps from 4 back to 0.
- R6: Command 0x5V sets brightness to V[2:0]. Command 0x6G sets the grid count to G[3:0].
- R7: Command 0x4Q sets the port to Q[1:0]. Command 0x7M sets the display mode to M[0] (1 shows RAM content, 0 forces all segments off). Data bytes after any of the commands 0x4 to 0x7 have no effect.
- R8: No store changes while chip enable is low. A frame's effect is visible within 4 system clocks after chip enable rises.
- R9: A partial byte cut short by chip enable rising is discarded, and the completed bytes of that frame are still committed. A frame with no complete command byte changes nothing.
- R10: Opcodes 0x0 and 0x8 to 0xF change no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_dat | input | 1 | Serial data, LSB first |
| ser_ce_n | input | 1 | Active-low frame enable |
| chr_raddr | input | 4 | Character RAM read address |
| chr_rdata | output | 8 | Character code at chr_raddr |
| seg_raddr | input | 4 | Segment RAM read address |
| seg_rdata | output | 2 | Segment bits at seg_raddr |
| udc_ridx | input | 3 | Pattern read index |
| udc_rcol | input | 3 | Pattern column read (0 to 4, others read 0) |
| udc_rdata | output | 7 | Pattern column bits |
| bright | output | 3 | Brightness level |
| grid_cnt | output | 4 | Grid count setting |
| disp_on | output | 1 | Display mode (1 show RAM, 0 all off) |
| port_out | output | 2 | Output port value |

## Verification
The assertions assume that each serial-clock level and each data bit last several system clocks. They also assume that chip enable never moves in the same synchronized cycle as a serial-clock rise, so that every rising edge is seen exactly once and the data bit is settled when it is seen. The stimulus holds each serial-clock phase for 4 system clocks and changes data only on the falling serial edge. It separates chip-enable edges from the first and last serial-clock edges by at least 4 system clocks. Within those limits, random frames vary the opcode, the argument, the length and a cut-short trailing byte.

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx #(
  parameter int DIGITS   = 16,
  parameter int SEG_W    = 2,
  parameter int UDC_N    = 8,
  parameter int UDC_COLS = 5,
  parameter int UDC_ROWS = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk,
  input  logic                        ser_dat,
  input  logic                        ser_ce_n,
  input  logic [$clog2(DIGITS)-1:0]   chr_raddr,
  output logic [7:0]                  chr_rdata,
  input  logic [$clog2(DIGITS)-1:0]   seg_raddr,
  output logic [SEG_W-1:0]            seg_rdata,
  input  logic [$clog2(UDC_N)-1:0]    udc_ridx,
  input  logic [2:0]                  udc_rcol,
  output logic [UDC_ROWS-1:0]         udc_rdata,
  output logic [2:0]                  bright,
  output logic [3:0]                  grid_cnt,
  output logic                        disp_on,
  output logic [1:0]                  port_out
);
  localparam int AW  = $clog2(DIGITS);
  localparam int UIW = $clog2(UDC_N);
  localparam int STG = DIGITS;
  localparam int UDC_BITS = UDC_N * UDC_COLS * UDC_ROWS;
  localparam logic [3:0] OP_CHR = 4'h1, OP_UDC = 4'h2, OP_SEG = 4'h3,
                         OP_PORT = 4'h4, OP_BRT = 4'h5, OP_GRID = 4'h6, OP_MODE = 4'h7;

  logic [2:0] s_clk, s_ce;
  logic [1:0] s_dat;
  logic sclk_rise, ce_fall, ce_rise, active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_clk <= '1;
      s_ce  <= '1;
      s_dat <= '0;
    end else begin
      s_clk <= {s_clk[1:0], ser_clk};
      s_ce  <= {s_ce[1:0], ser_ce_n};
      s_dat <= {s_dat[0], ser_dat};
    end

  assign sclk_rise = s_clk[1] & ~s_clk[2];
  assign ce_fall   = ~s_ce[1] & s_ce[2];
  assign ce_rise   = s_ce[1] & ~s_ce[2];
  assign active    = ~s_ce[1];

  logic [7:0] shreg, cmd_q;
  logic [2:0] bit_cnt;
  logic       have_cmd;
  logic [AW-1:0] ptr;
  logic [STG*8-1:0] stg;
  logic [STG-1:0]   stg_vld;
  logic [7:0] byte_nxt;
  logic [3:0] op;

  assign byte_nxt = {s_dat[1], shreg[7:1]};
  assign op = cmd_q[7:4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg    <= '0;
      cmd_q    <= '0;
      bit_cnt  <= '0;
      have_cmd <= 1'b0;
      ptr      <= '0;
      stg      <= '0;
      stg_vld  <= '0;
    end else if (ce_fall) begin
      bit_cnt  <= '0;
      have_cmd <= 1'b0;
      stg_vld  <= '0;
    end else if (sclk_rise && active) begin
      shreg   <= byte_nxt;
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (!have_cmd) begin
          cmd_q    <= byte_nxt;
          have_cmd <= 1'b1;
          ptr      <= (byte_nxt[7:4] == OP_UDC) ? '0 : byte_nxt[AW-1:0];
        end else begin
          stg[ptr*8 +: 8] <= byte_nxt;
          stg_vld[ptr]    <= 1'b1;
          if (op == OP_UDC)
            ptr <= (int'(ptr) == UDC_COLS-1) ? '0 : ptr + 1'b1;
          else
            ptr <= ptr + 1'b1;
        end
      end
    end

  logic [DIGITS*8-1:0]     chr_mem;
  logic [DIGITS*SEG_W-1:0] seg_mem;
  logic [UDC_BITS-1:0]     udc_mem;
  logic [UIW-1:0]          widx;

  assign widx = cmd_q[UIW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chr_mem  <= '0;
      seg_mem  <= '0;
      udc_mem  <= '0;
      bright   <= '0;
      grid_cnt <= '0;
      disp_on  <= 1'b0;
      port_out <= '0;
    end else if (ce_rise && have_cmd) begin
      case (op)
        OP_CHR:
          for (int i = 0; i < DIGITS; i++)
            if (stg_vld[i]) chr_mem[i*8 +: 8] <= stg[i*8 +: 8];
        OP_SEG:
          for (int i = 0; i < DIGITS; i++)
            if (stg_vld[i]) seg_mem[i*SEG_W +: SEG_W] <= stg[i*8 +: SEG_W];
        OP_UDC:
          for (int c = 0; c < UDC_COLS; c++)
            if (stg_vld[c])
              udc_mem[(int'(widx)*UDC_COLS + c)*UDC_ROWS +: UDC_ROWS] <= stg[c*8 +: UDC_ROWS];
        OP_PORT: port_out <= cmd_q[1:0];
        OP_BRT:  bright   <= cmd_q[2:0];
        OP_GRID: grid_cnt <= cmd_q[3:0];
        OP_MODE: disp_on  <= cmd_q[0];
        default: ;
      endcase
    end

  assign chr_rdata = chr_mem[chr_raddr*8 +: 8];
  assign seg_rdata = seg_mem[seg_raddr*SEG_W +: SEG_W];
  assign udc_rdata = (int'(udc_rcol) < UDC_COLS)
                   ? udc_mem[(int'(udc_ridx)*UDC_COLS + int'(udc_rcol))*UDC_ROWS +: UDC_ROWS]
                   : '0;

  p_frame_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> (bit_cnt == 3'd0 && !have_cmd && stg_vld == '0));
  p_chr_only_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chr_mem) |-> $past(ce_rise));
  p_seg_only_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_mem) |-> $past(ce_rise));
  p_udc_only_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(udc_mem) |-> $past(ce_rise));
  p_ctrl_only_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({bright, grid_cnt, disp_on, port_out}) |-> $past(ce_rise));
  p_udc_col_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (have_cmd && op == OP_UDC) |-> (int'(ptr) < UDC_COLS));
  p_cmd_latched_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (have_cmd && !ce_fall) |=> $stable(cmd_q));
endmodule

// File: tb/vfd_cmd_rx_bench.sv
module vfd_cmd_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b1, ser_dat = 1'b0, ser_ce_n = 1'b1;
  logic [3:0] chr_raddr = '0, seg_raddr = '0;
  logic [2:0] udc_ridx = '0, udc_rcol = '0;
  logic [7:0] chr_rdata;
  logic [1:0] seg_rdata, port_out;
  logic [6:0] udc_rdata;
  logic [2:0] bright;
  logic [3:0] grid_cnt;
  logic disp_on;

  vfd_cmd_rx u_vfd_cmd_rx (.*);

  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  logic [7:0] m_chr [16];
  logic [1:0] m_seg [16];
  logic [6:0] m_udc [8][5];
  logic [2:0] m_brt;
  logic [3:0] m_grid;
  logic [1:0] m_port;
  logic m_disp;
  logic [7:0] frm [0:31];
  int nfr;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      chr_raddr = 4'(i); seg_raddr = 4'(i); #1;
      chk({tag, " chr"}, int'(chr_rdata), int'(m_chr[i]));
      chk({tag, " seg"}, int'(seg_rdata), int'(m_seg[i]));
    end
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 5; c++) begin
        udc_ridx = 3'(p); udc_rcol = 3'(c); #1;
        chk({tag, " udc"}, int'(udc_rdata), int'(m_udc[p][c]));
      end
    chk({tag, " bright"}, int'(bright), int'(m_brt));
    chk({tag, " grid"}, int'(grid_cnt), int'(m_grid));
    chk({tag, " port"}, int'(port_out), int'(m_port));
    chk({tag, " disp"}, int'(disp_on), int'(m_disp));
  endtask

  task automatic model_apply();
    int p, c;
    if (nfr == 0) return;
    p = int'(frm[0][3:0]);
    c = 0;
    case (frm[0][7:4])
      4'h1: for (int i = 1; i < nfr; i++) begin m_chr[p] = frm[i]; p = (p + 1) % 16; end
      4'h3: for (int i = 1; i < nfr; i++) begin m_seg[p] = frm[i][1:0]; p = (p + 1) % 16; end
      4'h2: for (int i = 1; i < nfr; i++) begin m_udc[frm[0][2:0]][c] = frm[i][6:0]; c = (c + 1) % 5; end
      4'h4: m_port = frm[0][1:0];
      4'h5: m_brt  = frm[0][2:0];
      4'h6: m_grid = frm[0][3:0];
      4'h7: m_disp = frm[0][0];
      default: ;
    endcase
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    ser_clk = 1'b0; ser_dat = b; wait_clk(4);
    ser_clk = 1'b1; wait_clk(4);
  endtask

  task automatic begin_frame();
    nfr = 0;
    ser_ce_n = 1'b0; wait_clk(4);
  endtask

  task automatic put_byte(input logic [7:0] b);
    frm[nfr] = b; nfr++;
    for (int k = 0; k < 8; k++) put_bit(b[k]);
  endtask

  task automatic end_frame();
    wait_clk(4);
    ser_ce_n = 1'b1;
    model_apply();
    wait_clk(6);
  endtask

  initial begin
    wait_clk(5000 * 4);
    wait_clk(25000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin m_chr[i] = '0; m_seg[i] = '0; end
    for (int p = 0; p < 8; p++) for (int c = 0; c < 5; c++) m_udc[p][c] = '0;
    m_brt = '0; m_grid = '0; m_port = '0; m_disp = 1'b0;
    wait_clk(3); rst_n = 1'b1; wait_clk(3);
    check_all("R1 reset");

    begin_frame(); put_byte(8'h10); put_byte(8'h01); put_byte(8'hA5); end_frame();
    check_all("R2 lsb first");

    begin_frame(); put_byte(8'h1E);
    for (int i = 0; i < 5; i++) put_byte(8'(8'h30 + i));
    end_frame();
    check_all("R3 char wrap");

    begin_frame(); put_byte(8'h3F); put_byte(8'h03); put_byte(8'hFE); put_byte(8'h01); end_frame();
    check_all("R4 seg wrap");

    begin_frame(); put_byte(8'h2B);
    for (int i = 0; i < 7; i++) put_byte(8'(8'hF0 + 8'(i * 3)));
    end_frame();
    check_all("R5 udc col wrap");

    begin_frame(); put_byte(8'h57); put_byte(8'h00); end_frame();
    begin_frame(); put_byte(8'h6C); end_frame();
    check_all("R6 bright grid");

    begin_frame(); put_byte(8'h43); put_byte(8'hFF); end_frame();
    begin_frame(); put_byte(8'h71); end_frame();
    check_all("R7 port mode");

    begin_frame(); put_byte(8'h52); put_byte(8'h14); wait_clk(10);
    check_all("R8 held while ce low");
    end_frame();
    check_all("R8 after ce rise");

    begin_frame(); put_byte(8'h14); put_byte(8'h77);
    for (int k = 0; k < 5; k++) put_bit(1'b1);
    end_frame();
    check_all("R9 partial data");
    begin_frame();
    for (int k = 0; k < 6; k++) put_bit(1'b0);
    nfr = 0; end_frame();
    check_all("R9 partial command");

    begin_frame(); put_byte(8'h90); put_byte(8'h11); put_byte(8'h22); end_frame();
    begin_frame(); put_byte(8'h05); put_byte(8'h33); end_frame();
    check_all("R10 unknown opcode");

    for (int f = 0; f < 40; f++) begin
      int n, tail;
      logic [7:0] cmd;
      cmd = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) != 0) cmd[7:4] = 4'($urandom_range(1, 7));
      n = $urandom_range(0, 10);
      tail = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      begin_frame(); put_byte(cmd);
      for (int i = 0; i < n; i++) put_byte(8'($urandom_range(0, 255)));
      for (int k = 0; k < tail; k++) put_bit(1'($urandom_range(0, 1)));
      end_frame();
      check_all("R3 R4 R5 R6 R7 R9 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule